// File: doc/BRIEF.md
# Ethernet Receive Destination Address Filter

This block sits on the receive byte stream of an Ethernet port, just after the preamble and start delimiter have been removed. It looks at the six destination address bytes one per beat and decides whether the frame is wanted. The decision depends on a two-bit match mode and a 48-bit station address. A reject pulse comes out on the first byte that rules out every way of accepting the frame. That lets the downstream logic stop storing data at once and throw away what it has already written. An accept pulse comes out after the sixth byte, together with the class of the destination: unicast, multicast or broadcast.

The byte input uses a valid/ready handshake. The filter only watches the stream and never applies back-pressure, so `in_ready` is held high. A beat is taken on every cycle where `in_valid` is high, and idle cycles may fall anywhere inside the address. `in_first` marks the first destination byte of a frame. Beats that arrive after the decision, and before the next marked first byte, are ignored. The mode is captured on the first byte, so a change to the mode pins in the middle of a frame takes effect from the next frame.

Top module: `da_filter`

## Requirements
- R1: Mode 0 (receiver off): `drop` pulses in the cycle after the first byte, `pass` never pulses, and `done` is 1 with `pass_q` 0.
- R2: Mode 1 (promiscuous): every frame is accepted. `pass` pulses in the cycle after the sixth byte, and `drop` never pulses.
- R3: Mode 2: a frame is accepted only if its destination equals the station address or is all ones (broadcast).
- R4: Mode 3: a frame is accepted if its destination is the station address, the broadcast address, or any multicast address. A multicast address is one where bit 0 of the first byte is 1.
- R5: Byte k of the destination (k = 0 is the first byte received) is compared with `station_addr[8k+7:8k]`. `drop` pulses for one cycle, in the cycle after the first byte that leaves no way to accept the frame.
- R6: When `pass` pulses, `kind` gives the class of the destination: 0 for unicast (first-byte bit 0 clear), 1 for multicast (that bit set, not all ones), 2 for broadcast (all 48 bits set).
- R7: Once decided, `done`, `pass_q` and `kind` hold their values until the next beat with `in_first` set. Beats taken in between cause no pulse.
- R8: The mode is sampled on the first byte of a frame. A change on `match_mode` later in the same frame has no effect on that frame.
- R9: `in_ready` is always 1. A cycle with `in_valid` low is not a beat: it neither advances the byte count nor causes a pulse.
- R10: A synchronous active-high `rst` clears `done`, `pass_q`, `drop` and `pass`, and abandons any frame in progress. Later beats without `in_first` are ignored.
- R11: A beat with `in_first` set always restarts evaluation at byte 0, even in the middle of an undecided frame. It also clears `done` in the following cycle unless that byte decides the frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Byte beat present |
| in_ready | output | 1 | Always 1; the filter never stalls the stream |
| in_first | input | 1 | Marks the first destination byte of a frame |
| in_data | input | 8 | Destination address byte |
| match_mode | input | 2 | 0 off, 1 promiscuous, 2 station/broadcast, 3 station/broadcast/multicast |
| station_addr | input | 48 | Station address; bits 7:0 are matched against the first byte |
| drop | output | 1 | One-cycle reject pulse |
| pass | output | 1 | One-cycle accept pulse |
| done | output | 1 | A decision has been made for the current frame |
| pass_q | output | 1 | Held decision: 1 accepted, 0 rejected |
| kind | output | 2 | Destination class of an accepted frame |

## Verification
The bench runs every mode against destinations that match the station address, that are broadcast, and that are multicast. It also uses the station address with a single byte changed at each of the six positions, and the broadcast address with a single byte spoiled at each position. A filter that waited for all six bytes would reject late, and one that compared bytes against the wrong part of the station address would reject at the wrong position or accept the wrong frame. An all-ones address with its last byte spoiled must come out as multicast in mode 3 and be rejected at byte 5 in mode 2. A design that decided broadcast too early, or mixed up the two classes, fails on that case. The bench also flips the mode pins after each first byte, inserts idle cycles inside the address, sends extra bytes after the decision, restarts a frame in its middle and resets in its middle. A design that re-read the mode, counted idle cycles as bytes, or reacted to late bytes would pulse at the wrong time or change its held result.

// File: rtl/dafilt_pkg.sv
package dafilt_pkg;
  typedef enum logic [1:0] {
    MODE_OFF = 2'd0,
    MODE_ALL = 2'd1,
    MODE_SB  = 2'd2,
    MODE_SBM = 2'd3
  } match_mode_e;

  typedef enum logic [1:0] {
    KIND_UNI   = 2'd0,
    KIND_MULTI = 2'd1,
    KIND_BCAST = 2'd2
  } dest_kind_e;
endpackage

// File: rtl/daf_station_sel.sv
module daf_station_sel #(
  parameter int N_LANES = 6,
  parameter int LANE_W  = 8,
  parameter int IDX_W   = 3
) (
  input  logic [N_LANES*LANE_W-1:0] addr,
  input  logic [IDX_W-1:0]          idx,
  output logic [LANE_W-1:0]         lane
);
  logic [LANE_W-1:0] lanes [N_LANES];

  for (genvar g = 0; g < N_LANES; g++) begin : g_lane
    assign lanes[g] = addr[g*LANE_W +: LANE_W];
  end

  always_comb begin
    lane = '0;
    for (int i = 0; i < N_LANES; i++) begin
      if (idx == IDX_W'(i)) lane = lanes[i];
    end
  end
endmodule

// File: rtl/daf_track.sv
module daf_track
  import dafilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8,
  parameter int IDX_W      = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              beat,
  input  logic              first,
  input  logic [BYTE_W-1:0] data,
  input  match_mode_e       mode_in,
  input  logic [BYTE_W-1:0] sta_byte,
  input  logic              resolve,
  output logic              step,
  output logic [IDX_W-1:0]  cur_idx,
  output match_mode_e       cur_mode,
  output logic              sta_now,
  output logic              bc_now,
  output logic              mc_now,
  output logic              last
);
  logic             active_q;
  logic [IDX_W-1:0] idx_q;
  logic             sta_q, bc_q, mc_q;
  match_mode_e      mode_q;
  logic             start;

  assign start    = beat & first;
  assign step     = start | (beat & active_q);
  assign cur_idx  = start ? '0 : idx_q;
  assign cur_mode = start ? mode_in : mode_q;
  assign sta_now  = (start | sta_q) & (data == sta_byte);
  assign bc_now   = (start | bc_q) & (&data);
  assign mc_now   = start ? data[0] : mc_q;
  assign last     = (cur_idx == IDX_W'(ADDR_BYTES - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      active_q <= 1'b0;
      idx_q    <= '0;
      sta_q    <= 1'b0;
      bc_q     <= 1'b0;
      mc_q     <= 1'b0;
      mode_q   <= MODE_OFF;
    end else if (step) begin
      active_q <= ~resolve;
      idx_q    <= cur_idx + IDX_W'(1);
      sta_q    <= sta_now;
      bc_q     <= bc_now;
      mc_q     <= mc_now;
      mode_q   <= cur_mode;
    end
  end
endmodule

// File: rtl/daf_rules.sv
module daf_rules
  import dafilt_pkg::*;
(
  input  match_mode_e mode,
  input  logic        sta_now,
  input  logic        bc_now,
  input  logic        mc_now,
  input  logic        last,
  output logic        rej,
  output logic        acc,
  output dest_kind_e  kind_c
);
  logic alive;

  always_comb begin
    case (mode)
      MODE_OFF: alive = 1'b0;
      MODE_ALL: alive = 1'b1;
      MODE_SB:  alive = sta_now | bc_now;
      MODE_SBM: alive = sta_now | bc_now | mc_now;
      default:  alive = 1'b0;
    endcase
    rej = ~alive;
    acc = alive & last;
    if (bc_now)      kind_c = KIND_BCAST;
    else if (mc_now) kind_c = KIND_MULTI;
    else             kind_c = KIND_UNI;
  end
endmodule

// File: rtl/da_filter.sv
module da_filter
  import dafilt_pkg::*;
#(
  parameter int ADDR_BYTES = 6,
  parameter int BYTE_W     = 8
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         in_valid,
  output logic                         in_ready,
  input  logic                         in_first,
  input  logic [BYTE_W-1:0]            in_data,
  input  logic [1:0]                   match_mode,
  input  logic [ADDR_BYTES*BYTE_W-1:0] station_addr,
  output logic                         drop,
  output logic                         pass,
  output logic                         done,
  output logic                         pass_q,
  output logic [1:0]                   kind
);
  localparam int IDX_W = (ADDR_BYTES > 1) ? $clog2(ADDR_BYTES) : 1;

  logic              beat, step, sta_now, bc_now, mc_now, last, rej, acc;
  logic [IDX_W-1:0]  cur_idx;
  logic [BYTE_W-1:0] sta_byte;
  match_mode_e       cur_mode;
  dest_kind_e        kind_c;

  assign in_ready = 1'b1;
  assign beat     = in_valid & in_ready;

  daf_station_sel #(.N_LANES(ADDR_BYTES), .LANE_W(BYTE_W), .IDX_W(IDX_W)) u_sel (
    .addr (station_addr),
    .idx  (cur_idx),
    .lane (sta_byte)
  );

  daf_track #(.ADDR_BYTES(ADDR_BYTES), .BYTE_W(BYTE_W), .IDX_W(IDX_W)) u_track (
    .clk      (clk),
    .rst      (rst),
    .beat     (beat),
    .first    (in_first),
    .data     (in_data),
    .mode_in  (match_mode_e'(match_mode)),
    .sta_byte (sta_byte),
    .resolve  (rej | acc),
    .step     (step),
    .cur_idx  (cur_idx),
    .cur_mode (cur_mode),
    .sta_now  (sta_now),
    .bc_now   (bc_now),
    .mc_now   (mc_now),
    .last     (last)
  );

  daf_rules u_rules (
    .mode    (cur_mode),
    .sta_now (sta_now),
    .bc_now  (bc_now),
    .mc_now  (mc_now),
    .last    (last),
    .rej     (rej),
    .acc     (acc),
    .kind_c  (kind_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      drop   <= 1'b0;
      pass   <= 1'b0;
      done   <= 1'b0;
      pass_q <= 1'b0;
      kind   <= KIND_UNI;
    end else begin
      drop <= 1'b0;
      pass <= 1'b0;
      if (step) begin
        if (beat && in_first) begin
          done   <= 1'b0;
          pass_q <= 1'b0;
        end
        if (rej) begin
          drop   <= 1'b1;
          done   <= 1'b1;
          pass_q <= 1'b0;
        end else if (acc) begin
          pass   <= 1'b1;
          done   <= 1'b1;
          pass_q <= 1'b1;
          kind   <= kind_c;
        end
      end
    end
  end
endmodule

// File: rtl/daf_checker.sv
module daf_checker (
  input logic       clk,
  input logic       rst,
  input logic       in_valid,
  input logic       in_first,
  input logic [1:0] match_mode,
  input logic       drop,
  input logic       pass,
  input logic       done,
  input logic       pass_q,
  input logic [1:0] kind
);
  p_off_rejects_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first && match_mode == 2'd0) |=> (drop && !pass));

  p_promisc_no_drop_r2: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first && match_mode == 2'd1) |=> !drop);

  p_one_verdict_r5: assert property (@(posedge clk) disable iff (rst)
    !(drop && pass));

  p_drop_held_r7: assert property (@(posedge clk) disable iff (rst)
    drop |-> (done && !pass_q));

  p_pass_kind_r6: assert property (@(posedge clk) disable iff (rst)
    pass |-> (done && pass_q && kind != 2'd3));

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    (done && !(in_valid && in_first)) |=> (done && $stable(pass_q) && $stable(kind)));

  p_restart_r11: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_first) |=> (!done || drop || pass));
endmodule

bind da_filter daf_checker u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_valid   (in_valid),
  .in_first   (in_first),
  .match_mode (match_mode),
  .drop       (drop),
  .pass       (pass),
  .done       (done),
  .pass_q     (pass_q),
  .kind       (kind)
);

// File: tb/sim_da_filter.sv
`timescale 1ns/1ps
module sim_da_filter;
  localparam logic [47:0] STA = 48'h9A7856341210;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_first = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic [1:0]  match_mode = 2'd0;
  logic [47:0] station_addr = STA;
  logic        drop, pass, done, pass_q;
  logic [1:0]  kind;
  int          checks = 0;
  int          errors = 0;

  always #2.5 clk = ~clk;

  da_filter u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_first(in_first), .in_data(in_data), .match_mode(match_mode),
    .station_addr(station_addr), .drop(drop), .pass(pass), .done(done),
    .pass_q(pass_q), .kind(kind)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic put(input bit first, input logic [7:0] d);
    in_valid = 1'b1;
    in_first = first;
    in_data  = d;
    @(posedge clk);
    #1;
    in_valid = 1'b0;
    in_first = 1'b0;
  endtask

  task automatic idle();
    @(posedge clk);
    #1;
  endtask

  // Expected decision from the requirements: byte position of the verdict,
  // accept flag and destination class.
  task automatic model(input int md, input logic [47:0] da, output int pos,
                       output bit acc, output int kd);
    bit sa = 1, ba = 1, mc, alive;
    mc  = da[0];
    acc = 0; kd = 0; pos = 5;
    for (int k = 0; k < 6; k++) begin
      sa = sa && (da[8*k +: 8] == STA[8*k +: 8]);
      ba = ba && (da[8*k +: 8] == 8'hFF);
      case (md)
        0: alive = 0;
        1: alive = 1;
        2: alive = sa || ba;
        default: alive = sa || ba || mc;
      endcase
      if (!alive) begin
        pos = k;
        return;
      end
    end
    acc = 1;
    kd  = ba ? 2 : (mc ? 1 : 0);
  endtask

  task automatic run_frame(input int md, input logic [47:0] da, input logic [5:0] gaps);
    int pos, kd;
    bit acc;
    string tg;
    logic [1:0] mv;
    model(md, da, pos, acc, kd);
    mv = 2'(md);
    tg = (md == 0) ? "R1" : (md == 1) ? "R2" : (md == 2) ? "R3" : "R4";
    match_mode = mv;
    for (int k = 0; k < 6; k++) begin
      if (gaps[k] && k > 0) begin
        idle();
        chk(!drop && !pass, "R9 idle cycle pulse", {drop, pass}, 0);
      end
      put(k == 0, da[8*k +: 8]);
      if (k == 0) match_mode = mv ^ 2'b11;  // R8: mode flipped after first byte
      chk(drop == (!acc && k == pos), {tg, " R5 R8 drop"}, drop, (!acc && k == pos));
      chk(pass == (acc && k == pos), {tg, " R8 pass"}, pass, (acc && k == pos));
      if (k >= pos) chk(done && pass_q == acc, {tg, " R7 held"}, {done, pass_q}, {1'b1, acc});
      if (k == pos && acc) chk(kind == 2'(kd), "R6 kind", kind, kd);
    end
    for (int j = 0; j < 2; j++) begin
      put(1'b0, 8'hFF);
      chk(!drop && !pass && done && pass_q == acc, "R7 late bytes",
          {drop, pass, done, pass_q}, {2'b00, 1'b1, acc});
    end
  endtask

  initial begin
    logic [47:0] pat;
    repeat (3) @(posedge clk);
    #1;
    rst = 1'b0;
    chk(!done && !drop && !pass && !pass_q, "R10 reset state", {done, drop, pass, pass_q}, 0);
    chk(in_ready == 1'b1, "R9 ready", in_ready, 1);

    for (int md = 0; md < 4; md++) begin
      for (int p = 0; p < 15; p++) begin
        if (p == 0)      pat = STA;
        else if (p == 1) pat = '1;
        else if (p == 2) pat = STA | 48'h1;
        else if (p < 9)  pat = STA ^ (48'h40 << (8 * (p - 3)));
        else             pat = ~(48'h01 << (8 * (p - 9)));
        for (int g = 0; g < 2; g++) begin
          run_frame(md, pat, (g == 0) ? 6'b000000 : 6'b010110);
          chk(in_ready == 1'b1, "R9 ready", in_ready, 1);
        end
      end
    end

    // R11: restart inside an undecided frame
    match_mode = 2'd2;
    put(1'b1, STA[7:0]);
    put(1'b0, STA[15:8]);
    chk(!done && !drop, "R11 mid-frame undecided", {done, drop}, 0);
    run_frame(2, '1, 6'b0);
    put(1'b1, STA[7:0]);
    chk(!done && !pass_q, "R11 restart clears done", {done, pass_q}, 0);

    // R10: reset in the middle of a frame
    match_mode = 2'd1;
    put(1'b1, 8'h00);
    put(1'b0, 8'h00);
    rst = 1'b1;
    idle();
    rst = 1'b0;
    chk(!done && !drop && !pass, "R10 reset mid-frame", {done, drop, pass}, 0);
    for (int j = 0; j < 6; j++) begin
      put(1'b0, 8'h00);
      chk(!done && !drop && !pass, "R10 bytes after reset ignored", {done, drop, pass}, 0);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule